// File: doc/BRIEF.md
# Open-Drain Bus Line Driver with Multi-Master Arbitration

This block sits between a local bus master's bit sequencer and the two open-drain lines of an I2C bus. It turns a requested data bit and a clock-low request into pull-down enables. It never drives either line high. A one on the data line is sent by letting go of the line, and the pull-up raises it.

The block also watches for other masters on the same bus. While it is letting go of the data line, it compares the synchronized data level with the intended level on each synchronized rising clock edge. If the line reads low when high was intended, arbitration is lost. The block then lets go of both lines and records whether the loss happened while an address or a data byte was being sent.

A loss during a data byte raises a request to send the byte again later. A loss during an address raises a handover signal so that the slave receive path can keep listening and acknowledge if it is addressed. The lines stay released until a STOP is reported. The reporting flags stay set until the sequencer clears them.

Top module: `mm_line_arbiter`

## Requirements
- R1: While not in the lost state, `sda_pull` equals the inverse of `tx_bit` and `scl_pull` equals `scl_req`. A pull output of 1 means pull the line low, and 0 means high impedance.
- R2: A loss is only declared when `tx_bit` is 1 (line released). With `tx_bit` at 0, a low or a high data line never causes a loss.
- R3: The data line is checked only on a rising edge of the synchronized clock line, with two synchronizer stages. A data line falling while the clock line stays high causes no loss. After `scl_in` rises, the fault shows on `arb_lost` at the third rising `clk` edge and not before.
- R4: From the clock edge that sets `arb_lost`, both `sda_pull` and `scl_pull` are 0, whatever `tx_bit` and `scl_req` request.
- R5: The lost state, with both lines released, lasts until a one-cycle `stop_seen` pulse or `rst`. A `flag_clr` pulse does not end it.
- R6: `lost_stage` records the stage in which the loss happened, taken from `stage_sel`: 0 for address, 1 for data.
- R7: A loss with `stage_sel` = 1 (data) sets `resend_req`. A loss in the address stage does not set it.
- R8: A loss with `stage_sel` = 0 (address) sets `hand_to_slave`, which holds until `stop_seen` or `rst`. A data-stage loss leaves it at 0.
- R9: `arb_lost`, `lost_stage` and `resend_req` stay set after `stop_seen`. They are cleared only by a `flag_clr` pulse or `rst`.
- R10: After reset, `arb_lost`, `lost_stage`, `resend_req` and `hand_to_slave` are 0, and the pull outputs follow R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit | input | 1 | Requested data-line bit (1 = release) |
| scl_req | input | 1 | 1 = hold the clock line low |
| stage_sel | input | 1 | Current transfer stage: 0 address, 1 data |
| sda_in | input | 1 | Raw data-line level read from the bus |
| scl_in | input | 1 | Raw clock-line level read from the bus |
| stop_seen | input | 1 | One-cycle pulse: STOP detected on the bus |
| flag_clr | input | 1 | One-cycle pulse: clear the latched loss flags |
| sda_pull | output | 1 | Data-line pull-down enable |
| scl_pull | output | 1 | Clock-line pull-down enable |
| arb_lost | output | 1 | Latched arbitration-loss flag |
| lost_stage | output | 1 | Stage of the latched loss: 0 address, 1 data |
| resend_req | output | 1 | Latched request to resend the data byte |
| hand_to_slave | output | 1 | Address-stage loss: slave receive path takes over |

## Verification
The properties assume that `stop_seen` and `flag_clr` are single-cycle pulses. They also assume that `tx_bit` and `stage_sel` are held steady around each rising edge of the clock line, as a bit sequencer does. The stimulus sets up data level, requested bit and stage several cycles before raising `scl_in`, so the synchronized values have settled when the check happens. It only changes them while the clock line is low, or on purpose with the clock line high to show that no check is made without a rising edge.

// File: rtl/mm_arb_pkg.sv
package mm_arb_pkg;

    typedef enum logic {
        STG_ADDR = 1'b0,
        STG_DATA = 1'b1
    } xfer_stage_e;

    typedef struct packed {
        logic        lost;
        xfer_stage_e stage;
        logic        resend;
    } loss_rec_t;

    localparam int unsigned LINE_SDA = 0;
    localparam int unsigned LINE_SCL = 1;
    localparam int unsigned N_LINES  = 2;

    // Another master won when the line was released but reads low.
    function automatic logic arb_mismatch(input logic want_high, input logic seen);
        return want_high && !seen;
    endfunction

endpackage

// File: rtl/mm_sync_bank.sv
module mm_sync_bank #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned TOP = STAGES - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '1;            // idle bus lines float high
            else     sh <= {sh[STAGES-2:0], d[i]};
        end
        assign q[i] = sh[TOP];
    end
endmodule

// File: rtl/mm_rise_detect.sv
module mm_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev;
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= lvl;
    end
    assign rise = lvl && !prev;
endmodule

// File: rtl/mm_loss_ctrl.sv
module mm_loss_ctrl
    import mm_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        chk_en,
    input  logic        want_high,
    input  logic        sda_seen,
    input  xfer_stage_e stage_in,
    input  logic        stop_seen,
    input  logic        flag_clr,
    output logic        hold,
    output loss_rec_t   rec,
    output logic        hand
);
    logic detect;
    assign detect = chk_en && !hold && arb_mismatch(want_high, sda_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= 1'b0;
            hand <= 1'b0;
            rec  <= '0;
        end else begin
            if (detect)         hold <= 1'b1;
            else if (stop_seen) hold <= 1'b0;

            if (detect)         hand <= (stage_in == STG_ADDR);
            else if (stop_seen) hand <= 1'b0;

            if (detect) begin
                rec.lost   <= 1'b1;
                rec.stage  <= stage_in;
                rec.resend <= rec.resend || (stage_in == STG_DATA);
            end else if (flag_clr) begin
                rec <= '0;
            end
        end
    end
endmodule

// File: rtl/mm_line_arbiter.sv
module mm_line_arbiter
    import mm_arb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_bit,
    input  logic scl_req,
    input  logic stage_sel,
    input  logic sda_in,
    input  logic scl_in,
    input  logic stop_seen,
    input  logic flag_clr,
    output logic sda_pull,
    output logic scl_pull,
    output logic arb_lost,
    output logic lost_stage,
    output logic resend_req,
    output logic hand_to_slave
);
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               scl_rise;
    logic               hold;
    loss_rec_t          rec;
    xfer_stage_e        stage_e;

    assign raw_lines[LINE_SDA] = sda_in;
    assign raw_lines[LINE_SCL] = scl_in;
    assign stage_e = xfer_stage_e'(stage_sel);

    mm_sync_bank #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    mm_rise_detect i_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lines[LINE_SCL]),
        .rise (scl_rise)
    );

    mm_loss_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .chk_en    (scl_rise),
        .want_high (tx_bit),
        .sda_seen  (sync_lines[LINE_SDA]),
        .stage_in  (stage_e),
        .stop_seen (stop_seen),
        .flag_clr  (flag_clr),
        .hold      (hold),
        .rec       (rec),
        .hand      (hand_to_slave)
    );

    // Pull-down enables only: a high level is always a released line.
    assign sda_pull   = !hold && !tx_bit;
    assign scl_pull   = !hold && scl_req;
    assign arb_lost   = rec.lost;
    assign lost_stage = rec.stage;
    assign resend_req = rec.resend;
endmodule

// File: rtl/mm_line_arbiter_chk.sv
module mm_line_arbiter_chk (
    input logic clk,
    input logic rst,
    input logic tx_bit,
    input logic stop_seen,
    input logic flag_clr,
    input logic sda_pull,
    input logic scl_pull,
    input logic arb_lost,
    input logic lost_stage,
    input logic resend_req,
    input logic hand_to_slave
);
    p_pull_means_zero_r1: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> !tx_bit);

    p_loss_only_released_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> $past(tx_bit));

    p_release_both_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> (!sda_pull && !scl_pull));

    p_hand_held_r5: assert property (@(posedge clk) disable iff (rst)
        (hand_to_slave && !stop_seen) |=> hand_to_slave);

    p_resend_data_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(resend_req) |-> lost_stage);

    p_hand_addr_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(hand_to_slave) |-> (arb_lost && !lost_stage));

    p_flag_latched_r9: assert property (@(posedge clk) disable iff (rst)
        (arb_lost && !flag_clr) |=> arb_lost);
endmodule

bind mm_line_arbiter mm_line_arbiter_chk i_chk (.*);

// File: tb/test_mm_line_arbiter.sv
module test_mm_line_arbiter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_bit = 1'b1, scl_req = 1'b0, stage_sel = 1'b0;
    logic sda_in = 1'b1, scl_in = 1'b1, stop_seen = 1'b0, flag_clr = 1'b0;
    logic sda_pull, scl_pull, arb_lost, lost_stage, resend_req, hand_to_slave;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mm_line_arbiter i_mm_line_arbiter (.*);

    // {tx_bit, stage, sda level, exp lost, exp stage, exp resend, exp hand}
    localparam logic [6:0] VEC [6] = '{
        7'b1_0_0_1_0_0_1,   // address-stage loss
        7'b1_1_0_1_1_1_0,   // data-stage loss
        7'b1_0_1_0_0_0_0,   // released, line high: no loss
        7'b1_1_1_0_0_0_0,
        7'b0_0_0_0_0_0_0,   // driving low: never checked
        7'b0_1_1_0_0_0_0
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_stop_clr(input logic s, input logic c);
        stop_seen = s; flag_clr = c;
        step(1);
        stop_seen = 1'b0; flag_clr = 1'b0;
    endtask

    // clock line low, set up bit/stage/data level, then raise the clock line
    task automatic bit_cycle(input logic t, input logic st, input logic sda, input int wait_after);
        scl_in = 1'b0; tx_bit = t; stage_sel = st; sda_in = sda;
        step(4);
        scl_in = 1'b1;
        step(wait_after);
    endtask

    initial begin
        step(2);
        rst = 1'b0;
        step(1);
        chk("R10", "arb_lost", arb_lost, 1'b0);
        chk("R10", "lost_stage", lost_stage, 1'b0);
        chk("R10", "resend_req", resend_req, 1'b0);
        chk("R10", "hand_to_slave", hand_to_slave, 1'b0);
        chk("R10", "sda_pull", sda_pull, 1'b0);

        tx_bit = 1'b0; scl_req = 1'b1;
        step(1);
        chk("R1", "sda_pull low bit", sda_pull, 1'b1);
        chk("R1", "scl_pull req", scl_pull, 1'b1);
        scl_req = 1'b0;

        foreach (VEC[i]) begin
            bit_cycle(VEC[i][6], VEC[i][5], VEC[i][4], 3);
            chk("R2", "arb_lost", arb_lost, VEC[i][3]);
            chk("R6", "lost_stage", lost_stage, VEC[i][2]);
            chk("R7", "resend_req", resend_req, VEC[i][1]);
            chk("R8", "hand_to_slave", hand_to_slave, VEC[i][0]);
            chk("R4", "sda_pull", sda_pull, VEC[i][3] ? 1'b0 : !VEC[i][6]);
            scl_in = 1'b0;
            pulse_stop_clr(1'b1, 1'b1);
            sda_in = 1'b1;
            step(3);
        end

        // R3 latency, then R4/R5/R8 hold behaviour
        bit_cycle(1'b1, 1'b0, 1'b0, 2);
        chk("R3", "no flag before third edge", arb_lost, 1'b0);
        step(1);
        chk("R3", "flag on third edge", arb_lost, 1'b1);
        tx_bit = 1'b0; scl_req = 1'b1;
        step(1);
        chk("R4", "sda_pull in loss", sda_pull, 1'b0);
        chk("R4", "scl_pull in loss", scl_pull, 1'b0);
        pulse_stop_clr(1'b0, 1'b1);
        chk("R9", "arb_lost cleared", arb_lost, 1'b0);
        chk("R5", "sda still released after clr", sda_pull, 1'b0);
        chk("R8", "hand held after clr", hand_to_slave, 1'b1);
        pulse_stop_clr(1'b1, 1'b0);
        chk("R5", "sda_pull after stop", sda_pull, 1'b1);
        chk("R5", "scl_pull after stop", scl_pull, 1'b1);
        chk("R8", "hand after stop", hand_to_slave, 1'b0);
        scl_req = 1'b0;

        // R9: flags survive STOP
        bit_cycle(1'b1, 1'b1, 1'b0, 3);
        tx_bit = 1'b0;
        pulse_stop_clr(1'b1, 1'b0);
        chk("R9", "arb_lost after stop", arb_lost, 1'b1);
        chk("R9", "resend after stop", resend_req, 1'b1);
        chk("R9", "stage after stop", lost_stage, 1'b1);
        chk("R5", "lines driven again", sda_pull, 1'b1);
        pulse_stop_clr(1'b0, 1'b1);
        chk("R9", "resend cleared", resend_req, 1'b0);
        chk("R9", "stage cleared", lost_stage, 1'b0);

        // R3: data line falls while clock line stays high
        tx_bit = 1'b1; sda_in = 1'b1; scl_in = 1'b1;
        step(4);
        sda_in = 1'b0;
        step(6);
        chk("R3", "no check without rising edge", arb_lost, 1'b0);
        chk("R3", "lines not released", hand_to_slave, 1'b0);
        sda_in = 1'b1;

        // R10: reset in the middle of a loss
        bit_cycle(1'b1, 1'b0, 1'b0, 3);
        chk("R8", "loss before reset", hand_to_slave, 1'b1);
        rst = 1'b1; tx_bit = 1'b0;
        step(1);
        rst = 1'b0;
        step(1);
        chk("R10", "arb_lost after rst", arb_lost, 1'b0);
        chk("R10", "hand after rst", hand_to_slave, 1'b0);
        chk("R10", "sda_pull after rst", sda_pull, 1'b1);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule